// File: doc/BRIEF.md
# Subtract-and-Branch-if-Negative Processor

This block is a small multicycle processor with a single instruction. Each instruction occupies three consecutive words of an internal 256-word memory: a pointer A, a pointer B and a target C. The instruction replaces mem[B] with mem[B] - mem[A]. If the difference is negative, execution continues at C; otherwise it continues at the word after C. All memory traffic passes through an address register (MAR) and a data register (MDR). Operand A is parked in a temporary register R. One adder handles both the subtraction and the program-counter increments: it can complement its second input and force its carry-in.

The host loads a program through a word-wide host port while the core is stopped, then pulses `go`. The core starts at word 0 and runs until it takes a branch whose target is the address of the branching instruction's own first word. It then stops and raises `halt`, and the host reads results back through the same port.

The controller states, in order, are IDLE, FETCH_A, READ_A, LOAD_OP1, READ_OP1, HOLD_OP1, READ_B, LOAD_OP2, READ_OP2, SUB, WRITE, READ_C, BRANCH and HALT. The transitions are as follows:
- IDLE and HALT go to FETCH_A on `go`.
- Each state from FETCH_A through READ_C moves unconditionally to the next one in the list.
- BRANCH goes to HALT when the negative flag is set and the target equals the instruction's first address.
- Otherwise BRANCH returns to FETCH_A, loading PC from the target first if the negative flag is set.

Top module: `negbranch_cpu`

## Requirements
- R1: After reset, `busy`, `halt`, `flag_n` and `flag_z` are all 0.
- R2: While `busy` is 0, a high `host_we` writes `host_wdata` to word `host_addr` at the clock edge, and `host_rdata` shows the word at `host_addr` without delay.
- R3: `go` sampled while idle or halted starts execution at word address 0, and `busy` is 1 from the next cycle.
- R4: An instruction at word P reads words P, P+1 and P+2 as A, B and C, and stores (mem[B] - mem[A]) mod 2^32 at word B. Addresses are the low 8 bits of those words.
- R5: If bit 31 of the difference is 1, the next instruction starts at C; otherwise it starts at P+3.
- R6: `flag_n` equals bit 31 of the most recent difference, and `flag_z` is 1 exactly when that difference is zero. Both update only at the subtract step, which for the first instruction is the 9th rising edge after the edge that sampled `go`.
- R7: A taken branch with C equal to P sets `halt` to 1 and `busy` to 0 at the 12th edge after the instruction began. `halt` then stays 1 until the next `go`.
- R8: A not-taken instruction whose C equals P does not halt; execution falls through to P+3.
- R9: While `busy` is 1, `host_we` and `go` have no effect on memory or on execution.
- R10: Every instruction takes exactly 12 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse, honoured only when not busy |
| host_we | input | 1 | Host write enable, honoured only when not busy |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Word at host_addr |
| busy | output | 1 | Core is executing |
| halt | output | 1 | Core stopped on a self-targeted taken branch |
| flag_n | output | 1 | Sign of the last difference |
| flag_z | output | 1 | Last difference was zero |

## Verification
The hardest situations to reach from the ports are the two meanings of a self-target: taken, which halts, and not taken, which must fall through. The bench also has to land host writes and a stray `go` inside a run. Every program ends in a small halting instruction whose scratch cell shows at the port which branch path was followed. A counting loop exercises repeated backward branches, and the flags are sampled at the exact cycle after the first subtract.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_A,
        ST_READ_A,
        ST_LOAD_OP1,
        ST_READ_OP1,
        ST_HOLD_OP1,
        ST_READ_B,
        ST_LOAD_OP2,
        ST_READ_OP2,
        ST_SUB,
        ST_WRITE,
        ST_READ_C,
        ST_BRANCH,
        ST_HALT
    } cpu_state_e;

    typedef enum logic [1:0] {
        ADD_IDLE,
        ADD_INC,
        ADD_SUB
    } add_sel_e;

    typedef struct packed {
        logic     mar_pc;
        logic     mar_mdr;
        logic     mdr_mem;
        logic     mdr_sum;
        logic     r_load;
        logic     pc_clr;
        logic     pc_sum;
        logic     pc_tgt;
        logic     base_load;
        logic     mem_we;
        logic     flag_load;
        add_sel_e add_sel;
        logic     busy;
        logic     halt;
    } ctl_t;

endpackage

// File: rtl/nbc_adder.sv
module nbc_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         inv_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         neg,
    output logic         zero
);
    logic [W-1:0] b_eff;

    assign b_eff = inv_b ? ~b : b;
    assign sum   = a + b_eff + {{(W-1){1'b0}}, cin};
    assign neg   = sum[W-1];
    assign zero  = (sum == '0);
endmodule

// File: rtl/nbc_wordmem.sv
module nbc_wordmem #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/nbc_ctrl.sv
module nbc_ctrl
    import nbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       flag_n,
    input  logic       tgt_self,
    output cpu_state_e st,
    output ctl_t       ctl
);
    cpu_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE, ST_HALT: if (go) nxt = ST_FETCH_A;
            ST_FETCH_A:       nxt = ST_READ_A;
            ST_READ_A:        nxt = ST_LOAD_OP1;
            ST_LOAD_OP1:      nxt = ST_READ_OP1;
            ST_READ_OP1:      nxt = ST_HOLD_OP1;
            ST_HOLD_OP1:      nxt = ST_READ_B;
            ST_READ_B:        nxt = ST_LOAD_OP2;
            ST_LOAD_OP2:      nxt = ST_READ_OP2;
            ST_READ_OP2:      nxt = ST_SUB;
            ST_SUB:           nxt = ST_WRITE;
            ST_WRITE:         nxt = ST_READ_C;
            ST_READ_C:        nxt = ST_BRANCH;
            ST_BRANCH:        nxt = (flag_n && tgt_self) ? ST_HALT : ST_FETCH_A;
            default:          nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl      = '0;
        ctl.busy = 1'b1;
        unique case (st)
            ST_IDLE: begin
                ctl.busy   = 1'b0;
                ctl.pc_clr = go;
            end
            ST_HALT: begin
                ctl.busy   = 1'b0;
                ctl.halt   = 1'b1;
                ctl.pc_clr = go;
            end
            ST_FETCH_A: begin
                ctl.mar_pc    = 1'b1;
                ctl.base_load = 1'b1;
            end
            ST_READ_A, ST_READ_B, ST_READ_C: begin
                ctl.mdr_mem = 1'b1;
                ctl.add_sel = ADD_INC;
                ctl.pc_sum  = 1'b1;
            end
            ST_LOAD_OP1, ST_LOAD_OP2: ctl.mar_mdr = 1'b1;
            ST_READ_OP1, ST_READ_OP2: ctl.mdr_mem = 1'b1;
            ST_HOLD_OP1: begin
                ctl.r_load = 1'b1;
                ctl.mar_pc = 1'b1;
            end
            ST_SUB: begin
                ctl.add_sel   = ADD_SUB;
                ctl.mdr_sum   = 1'b1;
                ctl.flag_load = 1'b1;
            end
            ST_WRITE: begin
                ctl.mem_we = 1'b1;
                ctl.mar_pc = 1'b1;
            end
            ST_BRANCH: ctl.pc_tgt = flag_n && !tgt_self;
            default: ctl.busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/negbranch_cpu.sv
module negbranch_cpu
    import nbc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              busy,
    output logic              halt,
    output logic              flag_n,
    output logic              flag_z
);
    cpu_state_e st;
    ctl_t       ctl;

    logic [ADDR_W-1:0] pc, mar, ibase;
    logic [DATA_W-1:0] mdr, r_op;
    logic              flag_n_q, flag_z_q;

    logic [DATA_W-1:0] add_a, add_b, add_sum;
    logic              add_inv, add_cin, add_neg, add_zero;

    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic              mem_we, tgt_self;

    assign tgt_self = (mdr[ADDR_W-1:0] == ibase);

    nbc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .flag_n   (flag_n_q),
        .tgt_self (tgt_self),
        .st       (st),
        .ctl      (ctl)
    );

    always_comb begin
        add_a   = '0;
        add_b   = '0;
        add_inv = 1'b0;
        add_cin = 1'b0;
        case (ctl.add_sel)
            ADD_INC: begin
                add_a   = DATA_W'(pc);
                add_cin = 1'b1;
            end
            ADD_SUB: begin
                add_a   = mdr;
                add_b   = r_op;
                add_inv = 1'b1;
                add_cin = 1'b1;
            end
            default: ;
        endcase
    end

    nbc_adder #(.W(DATA_W)) u_adder (
        .a     (add_a),
        .b     (add_b),
        .inv_b (add_inv),
        .cin   (add_cin),
        .sum   (add_sum),
        .neg   (add_neg),
        .zero  (add_zero)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc       <= '0;
            mar      <= '0;
            ibase    <= '0;
            mdr      <= '0;
            r_op     <= '0;
            flag_n_q <= 1'b0;
            flag_z_q <= 1'b0;
        end else begin
            if (ctl.pc_clr)       pc <= '0;
            else if (ctl.pc_sum)  pc <= add_sum[ADDR_W-1:0];
            else if (ctl.pc_tgt)  pc <= mdr[ADDR_W-1:0];

            if (ctl.mar_pc)       mar <= pc;
            else if (ctl.mar_mdr) mar <= mdr[ADDR_W-1:0];

            if (ctl.base_load)    ibase <= pc;

            if (ctl.mdr_mem)      mdr <= mem_rdata;
            else if (ctl.mdr_sum) mdr <= add_sum;

            if (ctl.r_load)       r_op <= mdr;

            if (ctl.flag_load) begin
                flag_n_q <= add_neg;
                flag_z_q <= add_zero;
            end
        end
    end

    assign mem_addr  = ctl.busy ? mar : host_addr;
    assign mem_we    = ctl.busy ? ctl.mem_we : host_we;
    assign mem_wdata = ctl.busy ? mdr : host_wdata;

    nbc_wordmem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    assign host_rdata = mem_rdata;
    assign busy       = ctl.busy;
    assign halt       = ctl.halt;
    assign flag_n     = flag_n_q;
    assign flag_z     = flag_z_q;
endmodule

// File: rtl/negbranch_cpu_chk.sv
module negbranch_cpu_chk
    import nbc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       go,
    input logic       busy,
    input logic       halt,
    input logic       flag_n,
    input logic       flag_z,
    input cpu_state_e st
);
    // R7
    halt_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !busy);

    // R3
    go_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go) |=> busy);

    // R7
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !go) |=> halt);

    // R6
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_n && flag_z));

    // R6
    flag_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({flag_n, flag_z}) |-> $past(st) == ST_SUB);

    // R7
    halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |-> ($past(st) == ST_BRANCH && flag_n));
endmodule

bind negbranch_cpu negbranch_cpu_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .busy   (busy),
    .halt   (halt),
    .flag_n (flag_n),
    .flag_z (flag_z),
    .st     (st)
);

// File: tb/test_negbranch_cpu.sv
module test_negbranch_cpu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        busy, halt, flag_n, flag_z;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    negbranch_cpu i_negbranch_cpu (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .halt       (halt),
        .flag_n     (flag_n),
        .flag_z     (flag_z)
    );

    // {op1 at A, op2 at B}; B receives op2 - op1
    localparam logic [63:0] VEC [0:5] = '{
        {32'd5,         32'd9},
        {32'd9,         32'd5},
        {32'd7,         32'd7},
        {32'hFFFF_FFFF, 32'h7FFF_FFFF},
        {32'd1,         32'h8000_0000},
        {32'd0,         32'hFFFF_FFFE}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic put(input int a, input logic [31:0] d);
        host_addr  = a[7:0];
        host_wdata = d;
        host_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic peek(input int a, output logic [31:0] d);
        host_addr = a[7:0];
        #1;
        d = host_rdata;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 40; i++) put(i, 32'd0);
    endtask

    task automatic pulse_go();
        go = 1'b1;
        @(posedge clk);
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_halt(input string tag);
        int n = 0;
        while (!halt && n < 3000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        chk(tag, {31'd0, halt}, 32'd1);
    endtask

    // two-instruction frame: 0:(10,11,6) 3:(15,16,3) 6:(15,17,6)
    task automatic load_frame(input logic [31:0] a, input logic [31:0] b);
        clear_mem();
        put(0, 32'd10); put(1, 32'd11); put(2, 32'd6);
        put(3, 32'd15); put(4, 32'd16); put(5, 32'd3);
        put(6, 32'd15); put(7, 32'd17); put(8, 32'd6);
        put(10, a); put(11, b); put(15, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hung run expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 halt", {31'd0, halt}, 32'd0);
        chk("R1 flags", {30'd0, flag_n, flag_z}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 host write and read
        put(50, 32'hA5A5_1234);
        peek(50, rd);
        chk("R2 host readback", rd, 32'hA5A5_1234);

        // table walk: R4 result, R5 branch path, R6 flags
        for (int v = 0; v < 6; v++) begin
            logic [31:0] opa, opb, diff;
            opa  = VEC[v][63:32];
            opb  = VEC[v][31:0];
            diff = opb - opa;
            load_frame(opa, opb);
            pulse_go();
            chk("R3 busy after go", {31'd0, busy}, 32'd1);
            repeat (9) @(posedge clk);
            @(negedge clk);
            chk("R6 flag_n", {31'd0, flag_n}, {31'd0, diff[31]});
            chk("R6 flag_z", {31'd0, flag_z}, {31'd0, diff == 32'd0});
            wait_halt("R7 halted");
            peek(11, rd);
            chk("R4 difference", rd, diff);
            peek(16, rd);
            chk("R5 fallthrough path", rd, diff[31] ? 32'd0 : 32'hFFFF_FFFF);
            peek(17, rd);
            chk("R5 taken path", rd, diff[31] ? 32'hFFFF_FFFF : 32'd0);
        end

        // R10 / R7: single self-halting instruction, exact timing
        clear_mem();
        put(0, 32'd20); put(1, 32'd21); put(2, 32'd0);
        put(20, 32'd1);
        pulse_go();
        repeat (11) @(posedge clk);
        @(negedge clk);
        chk("R10 still running at edge 11", {30'd0, halt, busy}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        chk("R10 halted at edge 12", {30'd0, halt, busy}, 32'd2);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R7 halt held", {31'd0, halt}, 32'd1);
        peek(21, rd);
        chk("R4 self-halt result", rd, 32'hFFFF_FFFF);

        // R8: self target but not taken falls through
        clear_mem();
        put(0, 32'd20); put(1, 32'd21); put(2, 32'd0);
        put(3, 32'd15); put(4, 32'd16); put(5, 32'd3);
        put(15, 32'd1); put(21, 32'd5);
        pulse_go();
        wait_halt("R8 halted");
        peek(21, rd);
        chk("R8 result", rd, 32'd5);
        peek(16, rd);
        chk("R8 fell through to word 3", rd, 32'hFFFF_FFFF);

        // R9: host write and go while busy are ignored
        load_frame(32'd2, 32'd3);
        pulse_go();
        repeat (3) @(posedge clk);
        @(negedge clk);
        host_addr  = 8'd11;
        host_wdata = 32'h0000_DEAD;
        host_we    = 1'b1;
        go         = 1'b1;
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0;
        go      = 1'b0;
        wait_halt("R9 halted");
        peek(11, rd);
        chk("R9 cell untouched by host", rd, 32'd1);
        peek(16, rd);
        chk("R9 path", rd, 32'hFFFF_FFFF);

        // R5: counting loop 0:(31,30,6) 3:(34,35,0) 6:(31,36,6)
        clear_mem();
        put(0, 32'd31); put(1, 32'd30); put(2, 32'd6);
        put(3, 32'd34); put(4, 32'd35); put(5, 32'd0);
        put(6, 32'd31); put(7, 32'd36); put(8, 32'd6);
        put(30, 32'd5); put(31, 32'd1); put(34, 32'd1);
        pulse_go();
        wait_halt("R5 loop halted");
        peek(30, rd);
        chk("R5 loop counter", rd, 32'hFFFF_FFFF);
        peek(35, rd);
        chk("R5 backward jumps", rd, 32'hFFFF_FFFB);

        summary();
        $finish;
    end
endmodule